// File: doc/BRIEF.md
# RGB to BT.656 Interlaced Byte-Stream Formatter

The formatter turns a progressive 24-bit RGB picture into an interlaced 8-bit BT.656 stream. It is the timing master of its output. A free-running byte counter and a line counter lay out every output line. Each line begins with an end-of-active-video code, then carries horizontal blanking, a start-of-active-video code and the active samples.

The formatter fetches pixels itself. On every pixel slot it raises `px_rd` and drives the source row and column it wants. The source answers in the same cycle on `pix_rgb`. Field 0 asks for the even source rows and field 1 for the odd rows, so each output field carries every other progressive line.

Each fetched pixel is converted to Y, Cb and Cr with fixed-point BT.601 coefficients and clamped to the legal ranges. The samples are then multiplexed as Cb, Y, Cr, Y, with the chroma of each pair taken from its even pixel. Outside active video the stream holds the blanking pattern.

Top module: `rgb656_fmt`

## Requirements
- R1: While `rst_n` is low, `vid_byte` is 0x10 and `px_rd` is 0. The first byte after reset release is the first byte of field 0, line 0.
- R2: One output byte appears per clock, one clock after its position in the line is reached. A line is `8 + HBL_BYTES + 2*ACT_PIX` bytes long. Positions 0..3 hold the end-of-active-video code. Positions 4..3+HBL_BYTES hold blanking. The next four positions hold the start-of-active-video code, and the rest is the active region. Each code is the bytes FF, 00, 00, XY.
- R3: The XY byte is, from bit 7 down: 1, F, V, H, V^H, F^H, F^V, F^V^H. H is 1 in the end code and 0 in the start code. For example, field 0 in vertical blanking gives B6 and AB, and field 0 active gives 9D and 80.
- R4: Every non-code byte outside active video alternates 0x80 at even line positions and 0x10 at odd ones. This covers the active region of vertical-blanking lines.
- R5: Active bytes for a pixel pair (even pixel e, odd pixel o) are, in order, Cb(e), Y(e), Cr(e), Y(o).
- R6: Y = 16 + ((66R + 129G + 25B + 128) >> 8). Cb = 128 + ((-38R - 74G + 112B + 128) >>> 8). Cr = 128 + ((112R - 94G - 18B + 128) >>> 8). The shifts are arithmetic, so they floor.
- R7: Y is clamped to 16..235 and Cb/Cr to 16..240, so 0x00 and 0xFF never occur in active data.
- R8: `px_rd` is high exactly at the active positions 0 and 2 of each 4-byte group on non-blanking lines. At those times `px_col` is half the active offset, and `px_row` is `2*(line - VBL_LINES) + F`.
- R9: V is 1 on the first `VBL_LINES` lines of each field, which has `VBL_LINES + ACT_LINES` lines. F starts at 0 and toggles at every field boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_rgb | input | 24 | Source pixel {R,G,B}, valid in the cycle `px_rd` is high |
| px_rd | output | 1 | Pixel fetch strobe |
| px_row | output | $clog2(2*ACT_LINES) | Progressive source row being fetched |
| px_col | output | $clog2(ACT_PIX) | Source column being fetched |
| vid_byte | output | 8 | BT.656 output byte |

## Verification
The source pattern changes the colour between neighbouring pixels. A design that took chroma from the odd pixel, or swapped Cb and Cr, shows wrong bytes at fixed offsets in the first active line. Literal XY bytes are checked on both fields and on blanking and active lines. This catches a protection bit built from the wrong flags and an F that fails to toggle back in the second frame. The first active line of field 1 must show odd-row pixels, which exposes a design that repeats the even rows in both fields. A reset in the middle of a line must restart the stream with a fresh end code of field 0.

// File: rtl/rgb656_fmt.sv
module rgb656_fmt #(
  parameter int ACT_PIX   = 720,
  parameter int HBL_BYTES = 268,
  parameter int VBL_LINES = 20,
  parameter int ACT_LINES = 243,
  localparam int RW = $clog2(2*ACT_LINES),
  localparam int CW = $clog2(ACT_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [23:0]   pix_rgb,
  output logic          px_rd,
  output logic [RW-1:0] px_row,
  output logic [CW-1:0] px_col,
  output logic [7:0]    vid_byte
);
  localparam int LINE_BYTES = 8 + HBL_BYTES + 2*ACT_PIX;
  localparam int FLD_LINES  = VBL_LINES + ACT_LINES;
  localparam int HW = $clog2(LINE_BYTES);
  localparam int VW = $clog2(FLD_LINES);
  localparam logic [HW-1:0] SAV0  = HW'(4 + HBL_BYTES);
  localparam logic [HW-1:0] ACT0  = HW'(8 + HBL_BYTES);
  localparam logic [HW-1:0] HLAST = HW'(LINE_BYTES - 1);
  localparam logic [VW-1:0] VLAST = VW'(FLD_LINES - 1);
  localparam logic [VW-1:0] VBL   = VW'(VBL_LINES);

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic          fld;
  logic [7:0]    y0_r, cr_r, y1_r, nxt;

  wire vblk  = vc < VBL;
  wire in_e  = hc < HW'(4);
  wire in_s  = hc >= SAV0 && hc < ACT0;
  wire in_a  = hc >= ACT0;
  wire [HW-1:0] aofs = hc - ACT0;
  wire [HW-1:0] sofs = hc - SAV0;
  wire [VW-1:0] lrow = vc - VBL;
  wire [1:0]    cpos = in_e ? hc[1:0] : sofs[1:0];
  wire [7:0]    xy = {1'b1, fld, vblk, in_e, vblk ^ in_e, fld ^ in_e, fld ^ vblk, fld ^ vblk ^ in_e};

  assign px_rd  = in_a && !vblk && !aofs[0];
  assign px_col = CW'(aofs >> 1);
  assign px_row = RW'({lrow, fld});

  wire signed [19:0] rs = $signed({12'd0, pix_rgb[23:16]});
  wire signed [19:0] gs = $signed({12'd0, pix_rgb[15:8]});
  wire signed [19:0] bs = $signed({12'd0, pix_rgb[7:0]});
  wire signed [19:0] yv  = ((20'sd66 * rs + 20'sd129 * gs + 20'sd25 * bs + 20'sd128) >>> 8) + 20'sd16;
  wire signed [19:0] cbv = ((20'sd112 * bs - 20'sd38 * rs - 20'sd74 * gs + 20'sd128) >>> 8) + 20'sd128;
  wire signed [19:0] crv = ((20'sd112 * rs - 20'sd94 * gs - 20'sd18 * bs + 20'sd128) >>> 8) + 20'sd128;

  function automatic logic [7:0] clip(input logic signed [19:0] v, input logic [7:0] hi);
    if (v < 20'sd16) return 8'd16;
    else if (v > $signed({12'd0, hi})) return hi;
    else return v[7:0];
  endfunction

  wire [7:0] y_c  = clip(yv, 8'd235);
  wire [7:0] cb_c = clip(cbv, 8'd240);
  wire [7:0] cr_c = clip(crv, 8'd240);

  always_comb begin
    if (in_e || in_s) begin
      case (cpos)
        2'd0:    nxt = 8'hFF;
        2'd3:    nxt = xy;
        default: nxt = 8'h00;
      endcase
    end else if (!in_a || vblk) begin
      nxt = hc[0] ? 8'h10 : 8'h80;
    end else begin
      case (aofs[1:0])
        2'd0:    nxt = cb_c;
        2'd1:    nxt = y0_r;
        2'd2:    nxt = cr_r;
        default: nxt = y1_r;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; vc <= '0; fld <= 1'b0;
      vid_byte <= 8'h10;
      y0_r <= 8'h10; cr_r <= 8'h80; y1_r <= 8'h10;
    end else begin
      vid_byte <= nxt;
      if (px_rd && !aofs[1]) begin
        y0_r <= y_c;
        cr_r <= cr_c;
      end
      if (px_rd && aofs[1]) y1_r <= y_c;
      if (hc == HLAST) begin
        hc <= '0;
        if (vc == VLAST) begin
          vc  <= '0;
          fld <= ~fld;
        end else begin
          vc <= vc + 1'b1;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    px_rd |=> !px_rd); // R8
  AST_ROW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    px_rd |-> px_row[0] == fld); // R8
  AST_CODE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    vid_byte == 8'hFF |=> vid_byte == 8'h00); // R2
  AST_XY_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vid_byte, 3) == 8'hFF && $past(vid_byte, 2) == 8'h00 && $past(vid_byte) == 8'h00)
    |-> (vid_byte[7] && vid_byte[3] == (vid_byte[5] ^ vid_byte[4]) && vid_byte[2] == (vid_byte[6] ^ vid_byte[4])
         && vid_byte[1] == (vid_byte[6] ^ vid_byte[5]) && vid_byte[0] == (^vid_byte[6:4]))); // R3
  AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_a && !vblk) |-> (vid_byte >= 8'd16 && vid_byte <= 8'd240)); // R7
endmodule

// File: tb/sim_rgb656_fmt.sv
module sim_rgb656_fmt;
  localparam int CLK_NS = 10;
  localparam int AP = 4, HB = 4, VB = 2, AL = 3;
  localparam int LINE = 8 + HB + 2*AP;
  localparam int FLDB = (VB + AL) * LINE;
  localparam int RUN  = 2 * 2 * FLDB + 20;
  localparam int RW = $clog2(2*AL), CW = $clog2(AP);
  localparam int NV = 6;
  // {rgb, Y, Cb, Cr}
  localparam logic [47:0] VEC [NV] = '{
    {24'h000000, 8'd16,  8'd128, 8'd128},
    {24'hFFFFFF, 8'd235, 8'd128, 8'd128},
    {24'hFF0000, 8'd82,  8'd90,  8'd240},
    {24'h00FF00, 8'd144, 8'd54,  8'd34},
    {24'h0000FF, 8'd41,  8'd240, 8'd110},
    {24'h808080, 8'd126, 8'd128, 8'd128}
  };

  logic clk = 0, rst_n = 0;
  logic [23:0] pix_rgb;
  logic px_rd;
  logic [RW-1:0] px_row;
  logic [CW-1:0] px_col;
  logic [7:0] vid_byte;
  logic [7:0] rec [RUN];
  int total = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;
  always_comb pix_rgb = VEC[(int'(px_row) + int'(px_col)) % NV][47:24];

  rgb656_fmt #(.ACT_PIX(AP), .HBL_BYTES(HB), .VBL_LINES(VB), .ACT_LINES(AL)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_rgb(pix_rgb), .px_rd(px_rd),
    .px_row(px_row), .px_col(px_col), .vid_byte(vid_byte));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int n);
    int fp = n % (2*FLDB);
    int f = fp / FLDB, ln = (fp % FLDB) / LINE, h = fp % LINE;
    bit v = ln < VB, hh;
    int row, a;
    logic [47:0] e, o;
    if (h < 4 || (h >= 4+HB && h < 8+HB)) begin
      hh = h < 4;
      case (hh ? h : h - 4 - HB)
        0: return 8'hFF;
        3: return {1'b1, f[0], v, hh, v^hh, f[0]^hh, f[0]^v, f[0]^v^hh};
        default: return 8'h00;
      endcase
    end
    if (h < 8+HB || v) return (h % 2) ? 8'h10 : 8'h80;
    a = h - 8 - HB;
    row = 2*(ln - VB) + f;
    e = VEC[(row + 2*(a/4)) % NV];
    o = VEC[(row + 2*(a/4) + 1) % NV];
    case (a % 4)
      0: return e[15:8];
      1: return e[23:16];
      2: return e[7:0];
      default: return o[23:16];
    endcase
  endfunction

  function automatic string req_of(input int n);
    int fp = n % (2*FLDB);
    int ln = (fp % FLDB) / LINE, h = fp % LINE;
    if (h < 4 || (h >= 4+HB && h < 8+HB)) return "R3";
    if (h < 8+HB || ln < VB) return "R4";
    return "R5";
  endfunction

  initial begin
    #(CLK_NS * 20000);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vid_byte == 8'h10, "R1 reset byte", vid_byte, 8'h10);
    chk(px_rd == 1'b0, "R1 reset rd", px_rd, 0);
    rst_n = 1;
    for (int k = 1; k <= RUN; k++) begin
      int fp, ln, h, a;
      bit erd;
      @(negedge clk);
      rec[k-1] = vid_byte;
      chk(vid_byte == exp_byte(k-1), req_of(k-1), vid_byte, exp_byte(k-1));
      if (req_of(k-1) == "R5")
        chk(vid_byte >= 8'd16 && vid_byte <= 8'd240, "R7 range", vid_byte, 16);
      fp = k % (2*FLDB); ln = (fp % FLDB) / LINE; h = fp % LINE; a = h - 8 - HB;
      erd = (h >= 8+HB) && (ln >= VB) && (a % 2 == 0);
      chk(px_rd == erd, "R8 rd", px_rd, erd);
      if (erd) begin
        chk(int'(px_row) == 2*(ln - VB) + fp / FLDB, "R8 row", px_row, 2*(ln - VB) + fp / FLDB);
        chk(int'(px_col) == a / 2, "R8 col", px_col, a / 2);
      end
    end
    chk(rec[0] == 8'hFF && rec[1] == 8'h00 && rec[2] == 8'h00, "R2 code prefix", rec[0], 8'hFF);
    chk(rec[3] == 8'hB6, "R3 F0 V1 end", rec[3], 8'hB6);
    chk(rec[11] == 8'hAB, "R3 F0 V1 start", rec[11], 8'hAB);
    chk(rec[43] == 8'h9D, "R3 F0 active end", rec[43], 8'h9D);
    chk(rec[51] == 8'h80, "R3 F0 active start", rec[51], 8'h80);
    chk(rec[103] == 8'hF1, "R9 F1 blank end", rec[103], 8'hF1);
    chk(rec[111] == 8'hEC, "R9 F1 blank start", rec[111], 8'hEC);
    chk(rec[143] == 8'hDA, "R9 F1 active end", rec[143], 8'hDA);
    chk(rec[151] == 8'hC7, "R9 F1 active start", rec[151], 8'hC7);
    chk(rec[203] == 8'hB6, "R9 F back to 0", rec[203], 8'hB6);
    chk(rec[55] == 8'd235, "R5 Y of odd pixel", rec[55], 235);
    chk(rec[56] == 8'd90, "R5 Cb from even pixel", rec[56], 90);
    chk(rec[57] == 8'd82, "R6 Y red", rec[57], 82);
    chk(rec[58] == 8'd240, "R6 Cr red", rec[58], 240);
    chk(rec[59] == 8'd144, "R6 Y green", rec[59], 144);
    chk(rec[155] == 8'd82, "R8 field1 odd row", rec[155], 82);
    chk(rec[84] == 8'h80 && rec[85] == 8'h10, "R4 blank pattern", rec[84], 8'h80);
    repeat (7) @(negedge clk);
    rst_n = 0;
    #1;
    chk(vid_byte == 8'h10, "R1 mid reset byte", vid_byte, 8'h10);
    chk(px_rd == 1'b0, "R1 mid reset rd", px_rd, 0);
    @(negedge clk);
    rst_n = 1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(vid_byte == exp_byte(k-1), "R1 restart", vid_byte, exp_byte(k-1));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule